// File: doc/BRIEF.md
# PSK Phase Offset Sine Mapper

This block turns a decimal phase value into a 12-bit sine sample. The phase comes from a binary-coded-decimal accumulator that counts 8000 steps per turn. It arrives as one octal top digit followed by three decimal digits. A 3-bit modulation word is added to the top digit, so each unit of the word moves the phase by one eighth of a turn. With this, the output can carry two-, four- or eight-level phase-shift keying. The word can be changed on every cycle.

The modulated decimal phase is converted to a binary step index with constant-weight adders. A table holds one quarter of a sine wave and serves all four quadrants: addresses are mirrored in the falling quadrants, and the value is reflected about mid-scale in the lower half of the turn. The sample is registered. After reset it holds the zero-phase code until a non-zero phase or offset reaches it.

Top module: `psk_sine_mapper`

## Requirements
- R1: `phase_bcd` packs the phase as bits 14:12 = octal thousands digit (0..7), bits 11:8 = hundreds, bits 7:4 = tens and bits 3:0 = units, each 0..9. This encodes phase p = 1000·d3 + 100·d2 + 10·d1 + d0.
- R2: `pm_word` is added to the thousands digit modulo 8, so the modulated phase is (p + 1000·pm) mod 8000. Bit 2 of the word is half a turn, bit 1 a quarter turn and bit 0 an eighth of a turn.
- R3: For a modulated phase q, `sine_out` is within 1 LSB of 2048 + 2047·sin(2π·(q+0.5)/8000), in offset binary.
- R4: The output reflects the inputs sampled two rising clock edges earlier. If the inputs do not change, the output does not change.
- R5: A change of `pm_word` on each cycle gives a new correct sample on each cycle. The phase input is not disturbed.
- R6: A modulated phase of zero gives exactly 0x801.
- R7: Phases q and 3999−q give equal samples, and phases q and q+4000 give samples that sum to 4096.
- R8: While `rst_n` is low, `sine_out` is 0x801 at once. It stays 0x801 after release while both inputs are zero.
- R9: `sine_out` is never 0. The full range runs from 1 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_bcd | input | 15 | Decimal phase from the accumulator: octal top digit, then three decimal digits |
| pm_word | input | 3 | Phase-shift word in eighths of a turn, already registered upstream |
| sine_out | output | 12 | Registered offset-binary sine sample |

## Verification
A table of phases and offsets is applied. It places phases at each quadrant edge (0, 1999, 2000, 3999, 4000, 5999, 6000, 7999), at digit carries and at interior values, each under several offsets. This separates a wrong decimal weight, a wrong mirror point and a wrong reflection sign. Offsets that wrap the top digit past 7 show whether the addition is truly modulo 8. A run with the offset changed on every cycle, and a phase ramp with a moving offset, show whether the two-edge timing holds sample by sample. Symmetry pairs and the reset sequence pin the exact mid-scale codes.

// File: rtl/psk_sine_pkg.sv
package psk_sine_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // Rounded quarter-wave amplitude for entry k of a table covering
   // steps/4 entries, sampled at the centre of each step.
   function automatic int quarter_amp(int k, int steps, int amp);
      real ang;
      real val;
      ang = TWO_PI * (real'(k) + 0.5) / real'(steps);
      val = real'(amp) * $sin(ang);
      return $rtoi(val + 0.5);
   endfunction

   // Number of phase steps in one turn.
   function automatic int turn_steps(int top_bits, int low_digits);
      return (2 ** top_bits) * (10 ** low_digits);
   endfunction

endpackage

// File: rtl/bcd_phase_index.sv
module bcd_phase_index #(
   parameter int TOP_BITS   = 3,
   parameter int LOW_DIGITS = 3,
   parameter int IDX_W      = 13
) (
   input  logic [TOP_BITS+4*LOW_DIGITS-1:0] bcd,
   input  logic [TOP_BITS-1:0]              pm,
   output logic [IDX_W-1:0]                 idx
);
   localparam int BCD_W = TOP_BITS + 4*LOW_DIGITS;
   localparam int SPAN  = 10 ** LOW_DIGITS;
   localparam int STEPS = psk_sine_pkg::turn_steps(TOP_BITS, LOW_DIGITS);

   if (IDX_W < $clog2(STEPS)) begin : g_bad_width
      $error("bcd_phase_index: IDX_W too small for the turn");
   end

   // The offset wraps inside the top digit, which makes the turn modulo 8 digits.
   logic [TOP_BITS-1:0] top_rot;
   assign top_rot = bcd[BCD_W-1 -: TOP_BITS] + pm;

   logic [IDX_W-1:0] part [LOW_DIGITS+1];
   assign part[0] = IDX_W'(top_rot) * IDX_W'(SPAN);

   for (genvar g = 0; g < LOW_DIGITS; g++) begin : g_digit
      localparam int WEIGHT = 10 ** g;
      assign part[g+1] = part[g] + IDX_W'(bcd[4*g +: 4]) * IDX_W'(WEIGHT);
   end

   assign idx = part[LOW_DIGITS];
endmodule

// File: rtl/quarter_sine_lut.sv
module quarter_sine_lut #(
   parameter int IDX_W = 13,
   parameter int STEPS = 8000,
   parameter int OUT_W = 12
) (
   input  logic [IDX_W-1:0]             idx,
   output logic [$clog2(STEPS/4)-1:0]   addr_o,
   output logic [OUT_W-1:0]             code
);
   localparam int HALF = STEPS / 2;
   localparam int QD   = STEPS / 4;
   localparam int AW   = $clog2(QD);
   localparam int AMPW = OUT_W - 1;
   localparam int MID  = 2 ** (OUT_W - 1);
   localparam int AMP  = MID - 1;

   if (STEPS % 4 != 0) begin : g_bad_steps
      $error("quarter_sine_lut: STEPS must split into four quadrants");
   end

   logic [AMPW-1:0] amp_rom [QD];

   for (genvar k = 0; k < QD; k++) begin : g_tab
      localparam int V = psk_sine_pkg::quarter_amp(k, STEPS, AMP);
      assign amp_rom[k] = AMPW'(V);
   end

   logic             lower;
   logic [IDX_W-1:0] in_half;
   logic [IDX_W-1:0] fold;
   logic [AMPW-1:0]  amp;

   always_comb begin
      lower   = (idx >= IDX_W'(HALF));
      in_half = lower ? (idx - IDX_W'(HALF)) : idx;
      fold    = (in_half >= IDX_W'(QD)) ? (IDX_W'(HALF - 1) - in_half) : in_half;
      addr_o  = fold[AW-1:0];
      amp     = amp_rom[addr_o];
      code    = lower ? (OUT_W'(MID) - OUT_W'(amp)) : (OUT_W'(MID) + OUT_W'(amp));
   end
endmodule

// File: rtl/psk_sine_mapper.sv
module psk_sine_mapper #(
   parameter int TOP_BITS   = 3,
   parameter int LOW_DIGITS = 3,
   parameter int OUT_W      = 12,
   parameter int PIPE_INDEX = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [TOP_BITS+4*LOW_DIGITS-1:0]  phase_bcd,
   input  logic [TOP_BITS-1:0]               pm_word,
   output logic [OUT_W-1:0]                  sine_out
);
   localparam int BCD_W     = TOP_BITS + 4*LOW_DIGITS;
   localparam int STEPS     = psk_sine_pkg::turn_steps(TOP_BITS, LOW_DIGITS);
   localparam int IDX_W     = $clog2(STEPS);
   localparam int AW        = $clog2(STEPS/4);
   localparam int LAT       = 1 + PIPE_INDEX;
   localparam int MID       = 2 ** (OUT_W - 1);
   localparam int ZERO_CODE = MID + psk_sine_pkg::quarter_amp(0, STEPS, MID - 1);

   if (PIPE_INDEX < 0 || PIPE_INDEX > 1) begin : g_bad_pipe
      $error("psk_sine_mapper: PIPE_INDEX must be 0 or 1");
   end
   if (OUT_W < 4) begin : g_bad_out
      $error("psk_sine_mapper: OUT_W too narrow");
   end

   logic [IDX_W-1:0] idx_comb;
   logic [IDX_W-1:0] idx_use;
   logic [AW-1:0]    lut_addr;
   logic [OUT_W-1:0] lut_code;
   logic [OUT_W-1:0] sine_q;

   bcd_phase_index #(
      .TOP_BITS   (TOP_BITS),
      .LOW_DIGITS (LOW_DIGITS),
      .IDX_W      (IDX_W)
   ) u_index (
      .bcd (phase_bcd),
      .pm  (pm_word),
      .idx (idx_comb)
   );

   if (PIPE_INDEX == 1) begin : g_idx_reg
      logic [IDX_W-1:0] idx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) idx_q <= '0;
         else        idx_q <= idx_comb;
      end
      assign idx_use = idx_q;
   end else begin : g_idx_thru
      assign idx_use = idx_comb;
   end

   quarter_sine_lut #(
      .IDX_W (IDX_W),
      .STEPS (STEPS),
      .OUT_W (OUT_W)
   ) u_lut (
      .idx    (idx_use),
      .addr_o (lut_addr),
      .code   (lut_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sine_q <= OUT_W'(ZERO_CODE);
      else        sine_q <= lut_code;
   end

   assign sine_out = sine_q;

   // Cycles since reset, saturating; bounds how far back the checks may look.
   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   p_digits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_bcd[3:0] <= 4'd9) && (phase_bcd[7:4] <= 4'd9) && (phase_bcd[11:8] <= 4'd9))
      else $error("p_digits_r1: decimal digit out of range");

   p_index_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_comb < IDX_W'(STEPS))
      else $error("p_index_range_r2: index beyond one turn");

   p_fold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lut_addr < AW'(STEPS/4))
      else $error("p_fold_addr_r7: folded address outside quarter table");

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(warm_q) > LAT) &&
       ($past(phase_bcd, LAT) == $past(phase_bcd, LAT + 1)) &&
       ($past(pm_word, LAT) == $past(pm_word, LAT + 1))) |-> $stable(sine_out))
      else $error("p_hold_r4: output moved with steady inputs");

   p_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(warm_q) >= LAT) && ($past(phase_bcd, LAT) == '0) &&
       ($past(pm_word, LAT) == '0)) |-> (sine_out == OUT_W'(ZERO_CODE)))
      else $error("p_zero_code_r6: zero phase did not give the mid code");

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sine_out == OUT_W'(ZERO_CODE)))
      else $error("p_release_r8: output not at zero-phase code after reset");

   p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sine_out != '0)
      else $error("p_nonzero_r9: output reached code zero");
endmodule

// File: tb/psk_sine_mapper_bench.sv
module psk_sine_mapper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] phase_bcd = '0;
   logic [2:0]  pm_word = '0;
   logic [11:0] sine_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   psk_sine_mapper u_psk_sine_mapper (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_bcd (phase_bcd),
      .pm_word   (pm_word),
      .sine_out  (sine_out)
   );

   localparam int NV = 20;
   localparam int VEC_P [NV] = '{0, 1, 999, 1000, 1999, 2000, 2001, 3999, 4000, 4001,
                                 5999, 6000, 7999, 1234, 4567, 7001, 6999, 250, 3333, 7500};
   localparam int VEC_M [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 3,
                                 0, 0, 0, 1, 2, 4, 7, 5, 6, 3};

   function automatic logic [14:0] to_bcd(int p);
      return {3'(p / 1000), 4'((p / 100) % 10), 4'((p / 10) % 10), 4'(p % 10)};
   endfunction

   function automatic int model(int q);
      real x;
      x = 2047.0 * $sin(6.283185307179586 * (real'(q) + 0.5) / 8000.0);
      if (x >= 0.0) return 2048 + $rtoi(x + 0.5);
      else          return 2048 - $rtoi(-x + 0.5);
   endfunction

   function automatic int modulate(int p, int m);
      return (p + 1000 * m) % 8000;
   endfunction

   task automatic check(string req, int got, int exp, int tol);
      int d;
      d = got - exp;
      if (d < 0) d = -d;
      total++;
      if (d > tol) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic apply(int p, int m);
      @(negedge clk);
      phase_bcd = to_bcd(p);
      pm_word   = 3'(m);
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R8: reset state and hold after release with zero inputs
      repeat (3) @(negedge clk);
      check("R8 in reset", int'(sine_out), 2049, 0);
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check("R8 after release", int'(sine_out), 2049, 0);
      end

      // R1 R2 R3: vector table
      for (int i = 0; i < NV; i++) begin
         apply(VEC_P[i], VEC_M[i]);
         check("R3 vector", int'(sine_out), model(modulate(VEC_P[i], VEC_M[i])), 1);
         check("R9 nonzero", int'(sine_out != 12'd0), 1, 0);
      end

      // R1: digit weights distinct
      apply(10, 0);   check("R1 tens", int'(sine_out), model(10), 1);
      apply(100, 0);  check("R1 hundreds", int'(sine_out), model(100), 1);

      // R2: offsets wrapping the top digit
      for (int m = 0; m < 8; m++) begin
         apply(7123, m);
         check("R2 wrap", int'(sine_out), model(modulate(7123, m)), 1);
      end

      // R6: zero modulated phase, reached by wrapping
      apply(0, 0);    check("R6 zero", int'(sine_out), 2049, 0);
      apply(4000, 4); check("R6 wrap zero", int'(sine_out), 2049, 0);

      // R7: symmetry pairs
      for (int k = 0; k < 4; k++) begin
         int q;
         int a;
         int b;
         q = 17 + 613 * k;
         apply(q, 0);        a = int'(sine_out);
         apply(3999 - q, 0); b = int'(sine_out);
         check("R7 mirror", a, b, 0);
         apply(q + 4000, 0); b = int'(sine_out);
         check("R7 reflect", a + b, 4096, 0);
      end

      // R4: two-edge latency with a single change
      @(negedge clk);
      phase_bcd = to_bcd(1500); pm_word = 3'd0;
      repeat (3) @(negedge clk);
      phase_bcd = to_bcd(3000);
      @(negedge clk);
      check("R4 one edge", int'(sine_out), model(1500), 1);
      @(negedge clk);
      check("R4 two edges", int'(sine_out), model(3000), 1);
      @(negedge clk);
      check("R4 steady", int'(sine_out), model(3000), 1);

      // R5: offset changes every cycle, phase ramps
      begin
         int hist [2];
         int cnt;
         cnt = 0;
         for (int c = 0; c < 40; c++) begin
            int p;
            int m;
            @(negedge clk);
            if (cnt >= 2)
               check("R5 per cycle", int'(sine_out), hist[c % 2], 1);
            p = (2500 + 37 * c) % 8000;
            m = (c * 3) % 8;
            phase_bcd = to_bcd(p);
            pm_word   = 3'(m);
            hist[c % 2] = model(modulate(p, m));
            cnt++;
         end
      end

      // R8: reset in mid run returns at once to the mid code
      apply(1999, 0);
      rst_n = 1'b0;
      #1;
      check("R8 async", int'(sine_out), 2049, 0);
      phase_bcd = '0; pm_word = '0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 rerelease", int'(sine_out), 2049, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule